// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the purely combinational integer execute stage of a three-operand load/store processor. Each evaluation takes a 32-bit instruction word, the two source register values, an already sign-extended immediate and the current condition flags. It returns the result, a register write enable, the next value of the four condition flags and an illegal-operation indication. There is no state inside. The pipeline around it owns the register file and the flag register, and feeds `flagsOut` back into `flagsIn`.

A 6-bit function field in the instruction selects the operation. The unit executes the add and subtract family, the plain and inverted logic operations, add-with-carry and the three shifts. Each arithmetic and logic operation has a twin that also updates the flags. Any function code the unit does not execute is flagged as illegal and has no side effect.

Top module: `int_alu`

## Requirements
- R1: The function code is taken from instruction bits 24:19. Codes 0x00 add, 0x01 and, 0x02 or, 0x03 xor, 0x04 subtract, 0x05 a AND NOT b, 0x06 a OR NOT b, 0x07 XNOR, 0x08 add-with-carry, 0x25 shift left, 0x26 logical shift right and 0x27 arithmetic shift right produce the matching result with `writeEn` high.
- R2: When instruction bit 13 is one, the second operand is `immExt`. When it is zero, the second operand is `rs2Val`.
- R3: Codes 0x10 through 0x18 compute the same result as the code 0x10 lower and also update the flags.
- R4: Add-with-carry (0x08 and 0x18) increments the second operand by one before the sum when `flagsIn[0]` (C) is one.
- R5: For the flag-setting add forms, with a, b (b after any carry increment) and r the sign bits of first operand, second operand and result, V = (a&b&~r)|(~a&~b&r) and C = (a&b)|(~r&(a|b)).
- R6: For subtract-with-flags (0x14), V = (a&~b&~r)|(~a&b&r) and C = (~a&b)|(r&(~a|b)).
- R7: The flag vector is {N,Z,V,C} in bits 3..0. Every flag-setting code sets Z when the result is zero and N to result bit 31. The logic codes 0x11, 0x12, 0x13, 0x15, 0x16 and 0x17 force V and C to zero.
- R8: Every code other than 0x10 through 0x18 drives `flagsOut` equal to `flagsIn`.
- R9: Shifts use only the low 5 bits of the second operand as the amount. Arithmetic right shift fills the vacated upper bits with bit 31 of the first operand.
- R10: Every code not listed in R1 or R3 (for example 0x09..0x0F, 0x19..0x1F, 0x3A) raises `illegalOp`, drops `writeEn`, drives `result` to zero and passes `flagsIn` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word; function field and immediate select are decoded from it |
| rs1Val | input | 32 | First source register value |
| rs2Val | input | 32 | Second source register value |
| immExt | input | 32 | Sign-extended immediate operand |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Destination register write enable |
| flagsOut | output | 4 | Next flags {N,Z,V,C} |
| illegalOp | output | 1 | Function code not executed by this unit |

## Verification
In add-with-carry with flags, the incoming carry is consumed and the outgoing carry is produced in the same evaluation. The increment can also move the second operand's sign bit, and the V and C equations then see the incremented operand. Vectors with C set and the second operand at 0x7FFFFFFF or 0xFFFFFFFE provoke exactly that, and the flags are judged against the sign-bit equations worked out by hand. A sweep over all 64 function codes checks the illegal decode and flag pass-through together.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int INSTR_W  = 32;
  localparam int FUNC_HI  = 24;
  localparam int FUNC_LO  = 19;
  localparam int FUNC_W   = FUNC_HI - FUNC_LO + 1;
  localparam int IMM_POS  = 13;
  localparam int FLAG_W   = 4;
  localparam int FLAG_N   = 3;
  localparam int FLAG_Z   = 2;
  localparam int FLAG_V   = 1;
  localparam int FLAG_C   = 0;
  localparam int LAST_BASE = 8;

  typedef enum logic [3:0] {
    OP_ADD, OP_AND, OP_OR, OP_XOR, OP_SUB, OP_ANDN,
    OP_ORN, OP_XNOR, OP_SLL, OP_SRL, OP_SRA
  } alu_op_e;

  typedef struct packed {
    alu_op_e opSel;
    logic    carryIn;
    logic    immSel;
    logic    setFlags;
    logic    legal;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcCode,
  input  logic              immBit,
  input  logic              carryFlag,
  output alu_ctrl_t         ctrl
);

  logic [3:0] baseCode;
  logic       baseLegal;

  assign baseCode  = funcCode[3:0];
  assign baseLegal = (baseCode <= 4'(LAST_BASE));

  always_comb begin
    ctrl          = '0;
    ctrl.opSel    = OP_ADD;
    ctrl.immSel   = immBit;
    if (!funcCode[5]) begin
      ctrl.legal    = baseLegal;
      ctrl.setFlags = funcCode[4] & baseLegal;
      case (baseCode)
        4'h0: ctrl.opSel = OP_ADD;
        4'h1: ctrl.opSel = OP_AND;
        4'h2: ctrl.opSel = OP_OR;
        4'h3: ctrl.opSel = OP_XOR;
        4'h4: ctrl.opSel = OP_SUB;
        4'h5: ctrl.opSel = OP_ANDN;
        4'h6: ctrl.opSel = OP_ORN;
        4'h7: ctrl.opSel = OP_XNOR;
        4'h8: begin
          ctrl.opSel   = OP_ADD;
          ctrl.carryIn = carryFlag;
        end
        default: ctrl.opSel = OP_ADD;
      endcase
    end else if (funcCode[5:3] == 3'b100) begin
      case (funcCode[2:0])
        3'h5: begin ctrl.opSel = OP_SLL; ctrl.legal = 1'b1; end
        3'h6: begin ctrl.opSel = OP_SRL; ctrl.legal = 1'b1; end
        3'h7: begin ctrl.opSel = OP_SRA; ctrl.legal = 1'b1; end
        default: ctrl.legal = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctrl_t          ctrl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   rs2Val,
  input  logic [WIDTH-1:0]   immExt,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [WIDTH-1:0]   result,
  output logic [FLAG_W-1:0]  flagsOut
);

  localparam int SH_W = $clog2(WIDTH);
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] opB, opBEff, sumVal, diffVal, resVal;
  logic [SH_W-1:0]  shAmt;
  logic             aSign, bSign, rSign, vFlag, cFlag;

  assign opB    = ctrl.immSel ? immExt : rs2Val;
  assign opBEff = opB + {{(WIDTH-1){1'b0}}, ctrl.carryIn};
  assign sumVal = opA + opBEff;
  assign diffVal = opA - opB;
  assign shAmt  = opB[SH_W-1:0];

  always_comb begin
    case (ctrl.opSel)
      OP_ADD:  resVal = sumVal;
      OP_SUB:  resVal = diffVal;
      OP_AND:  resVal = opA & opB;
      OP_OR:   resVal = opA | opB;
      OP_XOR:  resVal = opA ^ opB;
      OP_ANDN: resVal = opA & ~opB;
      OP_ORN:  resVal = opA | ~opB;
      OP_XNOR: resVal = ~(opA ^ opB);
      OP_SLL:  resVal = opA << shAmt;
      OP_SRL:  resVal = opA >> shAmt;
      OP_SRA:  resVal = $unsigned($signed(opA) >>> shAmt);
      default: resVal = '0;
    endcase
  end

  assign result = ctrl.legal ? resVal : '0;

  assign aSign = opA[MSB];
  assign bSign = (ctrl.opSel == OP_SUB) ? opB[MSB] : opBEff[MSB];
  assign rSign = resVal[MSB];

  always_comb begin
    vFlag = 1'b0;
    cFlag = 1'b0;
    if (ctrl.opSel == OP_ADD) begin
      vFlag = (aSign & bSign & ~rSign) | (~aSign & ~bSign & rSign);
      cFlag = (aSign & bSign) | (~rSign & (aSign | bSign));
    end else if (ctrl.opSel == OP_SUB) begin
      vFlag = (aSign & ~bSign & ~rSign) | (~aSign & bSign & rSign);
      cFlag = (~aSign & bSign) | (rSign & (~aSign | bSign));
    end
  end

  always_comb begin
    flagsOut = flagsIn;
    if (ctrl.legal && ctrl.setFlags) begin
      flagsOut[FLAG_N] = rSign;
      flagsOut[FLAG_Z] = (resVal == '0);
      flagsOut[FLAG_V] = vFlag;
      flagsOut[FLAG_C] = cFlag;
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [WIDTH-1:0]   rs1Val,
  input  logic [WIDTH-1:0]   rs2Val,
  input  logic [WIDTH-1:0]   immExt,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [WIDTH-1:0]   result,
  output logic               writeEn,
  output logic [FLAG_W-1:0]  flagsOut,
  output logic               illegalOp
);

  alu_ctrl_t ctrl;
  logic      unusedInstrBits;

  assign unusedInstrBits = ^{instrWord[INSTR_W-1:FUNC_HI+1],
                             instrWord[FUNC_LO-1:IMM_POS+1],
                             instrWord[IMM_POS-1:0]};

  int_alu_ctrl u_ctrl (
    .funcCode  (instrWord[FUNC_HI:FUNC_LO]),
    .immBit    (instrWord[IMM_POS]),
    .carryFlag (flagsIn[FLAG_C]),
    .ctrl      (ctrl)
  );

  int_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .ctrl     (ctrl),
    .opA      (rs1Val),
    .rs2Val   (rs2Val),
    .immExt   (immExt),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );

  assign writeEn   = ctrl.legal;
  assign illegalOp = ~ctrl.legal;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [INSTR_W-1:0] instrWord,
  input logic [WIDTH-1:0]   rs1Val,
  input logic [WIDTH-1:0]   rs2Val,
  input logic [FLAG_W-1:0]  flagsIn,
  input logic [WIDTH-1:0]   result,
  input logic               writeEn,
  input logic [FLAG_W-1:0]  flagsOut,
  input logic               illegalOp
);

  logic [FUNC_W-1:0] fc;
  logic              immOn;
  assign fc    = instrWord[FUNC_HI:FUNC_LO];
  assign immOn = instrWord[IMM_POS];

  always_comb begin
    if (illegalOp)
      p_illegal_quiet_r10: assert (!writeEn && result == '0 && flagsOut == flagsIn)
        else $error("illegal code wrote or changed flags");
    if (fc[5:4] != 2'b01 || fc[3:0] > 4'd8)
      p_plain_flags_r8: assert (flagsOut == flagsIn)
        else $error("non flag-setting code changed flags");
    if (fc[5:4] == 2'b01 && fc[3:0] <= 4'd8)
      p_nz_flags_r7: assert (flagsOut[FLAG_Z] == (result == '0) &&
                             flagsOut[FLAG_N] == result[WIDTH-1])
        else $error("N/Z flags do not match result");
    if (fc[5:4] == 2'b01 && fc[3] == 1'b0 && fc[2:0] != 3'd0 && fc[2:0] != 3'd4)
      p_logic_cv_clear_r7: assert (flagsOut[FLAG_V] == 1'b0 && flagsOut[FLAG_C] == 1'b0)
        else $error("logic op left V or C set");
    if (fc == 6'h04 && !immOn)
      p_sub_inverse_r6: assert (result + rs2Val == rs1Val)
        else $error("subtract result inconsistent");
    if (fc == 6'h25 && !immOn && rs2Val[4:0] == 5'd0)
      p_shift_mask_r9: assert (result == rs1Val)
        else $error("shift by masked zero altered operand");
  end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_int_alu_chk (
  .instrWord (instrWord),
  .rs1Val    (rs1Val),
  .rs2Val    (rs2Val),
  .flagsIn   (flagsIn),
  .result    (result),
  .writeEn   (writeEn),
  .flagsOut  (flagsOut),
  .illegalOp (illegalOp)
);

// File: tb/test_int_alu.sv
module test_int_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  typedef struct packed {
    logic [5:0]  fc;
    logic        imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] iv;
    logic [3:0]  fin;
    logic [31:0] expR;
    logic [3:0]  expF;
    logic        expWe;
    logic [7:0]  req;
  } vec_t;

  // flags are {N,Z,V,C}
  localparam vec_t VECS [NV] = '{
    '{6'h00,1'b0,32'd5,32'd7,32'd0,4'b1010,32'd12,4'b1010,1'b1,8'd1},                    // R1 R8 add
    '{6'h01,1'b0,32'hF0F0F0F0,32'hFF00FF00,32'd0,4'b0000,32'hF000F000,4'b0000,1'b1,8'd1},// R1 and
    '{6'h02,1'b0,32'h0F0F0000,32'h000000F0,32'd0,4'b0000,32'h0F0F00F0,4'b0000,1'b1,8'd1},// R1 or
    '{6'h03,1'b0,32'hFFFF0000,32'h0F0F0F0F,32'd0,4'b0000,32'hF0F00F0F,4'b0000,1'b1,8'd1},// R1 xor
    '{6'h05,1'b0,32'hFFFFFFFF,32'h0000FFFF,32'd0,4'b0000,32'hFFFF0000,4'b0000,1'b1,8'd1},// R1 andn
    '{6'h06,1'b0,32'h0,32'hFFFFFFF0,32'd0,4'b0000,32'h0000000F,4'b0000,1'b1,8'd1},       // R1 orn
    '{6'h07,1'b0,32'h12345678,32'h12345678,32'd0,4'b0000,32'hFFFFFFFF,4'b0000,1'b1,8'd1},// R1 xnor
    '{6'h00,1'b1,32'd10,32'd999,32'hFFFFFFFF,4'b0000,32'd9,4'b0000,1'b1,8'd2},           // R2 imm
    '{6'h10,1'b0,32'h7FFFFFFF,32'd1,32'd0,4'b0101,32'h80000000,4'b1010,1'b1,8'd5},       // R5 overflow
    '{6'h10,1'b0,32'hFFFFFFFF,32'd1,32'd0,4'b0000,32'h0,4'b0101,1'b1,8'd5},              // R5 carry
    '{6'h14,1'b0,32'd5,32'd7,32'd0,4'b0000,32'hFFFFFFFE,4'b1001,1'b1,8'd6},              // R6 borrow
    '{6'h14,1'b0,32'h80000000,32'd1,32'd0,4'b0000,32'h7FFFFFFF,4'b0010,1'b1,8'd6},       // R6 overflow
    '{6'h14,1'b0,32'd3,32'd3,32'd0,4'b1111,32'h0,4'b0100,1'b1,8'd6},                     // R6 equal
    '{6'h08,1'b0,32'd10,32'd20,32'd0,4'b0001,32'd31,4'b0001,1'b1,8'd4},                  // R4 carry in
    '{6'h08,1'b0,32'd10,32'd20,32'd0,4'b0000,32'd30,4'b0000,1'b1,8'd4},                  // R4 no carry
    '{6'h18,1'b0,32'h0,32'h7FFFFFFF,32'd0,4'b0001,32'h80000000,4'b1000,1'b1,8'd4},       // R4 sign move
    '{6'h18,1'b0,32'd1,32'hFFFFFFFE,32'd0,4'b0001,32'h0,4'b0101,1'b1,8'd4},              // R4 carry out
    '{6'h11,1'b0,32'h80000000,32'hFFFFFFFF,32'd0,4'b0011,32'h80000000,4'b1000,1'b1,8'd7},// R7 andcc
    '{6'h13,1'b0,32'hAAAA,32'hAAAA,32'd0,4'b1111,32'h0,4'b0100,1'b1,8'd7},               // R7 xorcc
    '{6'h25,1'b0,32'd1,32'h24,32'd0,4'b0000,32'h10,4'b0000,1'b1,8'd9},                   // R9 mask
    '{6'h26,1'b0,32'h80000000,32'd31,32'd0,4'b0000,32'd1,4'b0000,1'b1,8'd9},             // R9 srl
    '{6'h27,1'b0,32'h80000000,32'd4,32'd0,4'b0000,32'hF8000000,4'b0000,1'b1,8'd9},       // R9 sra
    '{6'h27,1'b1,32'h7FFFFFFF,32'd0,32'h21,4'b0000,32'h3FFFFFFF,4'b0000,1'b1,8'd9},      // R9 imm
    '{6'h09,1'b0,32'd1,32'd1,32'd0,4'b1010,32'h0,4'b1010,1'b0,8'd10},                    // R10
    '{6'h1F,1'b0,32'd1,32'd1,32'd0,4'b0110,32'h0,4'b0110,1'b0,8'd10},                    // R10
    '{6'h3A,1'b0,32'd1,32'd1,32'd0,4'b1001,32'h0,4'b1001,1'b0,8'd10},                    // R10
    '{6'h04,1'b0,32'd3,32'd5,32'd0,4'b1111,32'hFFFFFFFE,4'b1111,1'b1,8'd1},              // R1 R8 sub
    '{6'h12,1'b0,32'd0,32'd0,32'd0,4'b1011,32'h0,4'b0100,1'b1,8'd3},                     // R3 orcc
    '{6'h04,1'b1,32'd100,32'd7,32'hFFFFFFF6,4'b0000,32'd110,4'b0000,1'b1,8'd2}           // R2 sub imm
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = '0, rs1Val = '0, rs2Val = '0, immExt = '0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] result;
  logic        writeEn, illegalOp;
  logic [3:0]  flagsOut;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu i_int_alu (
    .instrWord (instrWord), .rs1Val (rs1Val), .rs2Val (rs2Val), .immExt (immExt),
    .flagsIn (flagsIn), .result (result), .writeEn (writeEn),
    .flagsOut (flagsOut), .illegalOp (illegalOp)
  );

  function automatic logic [31:0] mkInstr(logic [5:0] fc, logic imm);
    return {2'b10, 5'd1, fc, 5'd2, imm, 13'd0};
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] fc, logic imm, logic [31:0] a, logic [31:0] b,
                       logic [31:0] iv, logic [3:0] fin);
    @(posedge clk);
    instrWord = mkInstr(fc, imm);
    rs1Val = a; rs2Val = b; immExt = iv; flagsIn = fin;
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset-time inputs are all zero: add of zeros, flags pass (R1 R8)
    check("R1 idle result", result, 32'h0);
    check("R1 idle writeEn", {31'd0, writeEn}, 32'd1);
    check("R8 idle flags", {28'd0, flagsOut}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].fc, VECS[i].imm, VECS[i].a, VECS[i].b, VECS[i].iv, VECS[i].fin);
      check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].expR);
      check($sformatf("R%0d vec%0d flags", VECS[i].req, i), {28'd0, flagsOut}, {28'd0, VECS[i].expF});
      check($sformatf("R%0d vec%0d writeEn", VECS[i].req, i), {31'd0, writeEn}, {31'd0, VECS[i].expWe});
      check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), {31'd0, illegalOp}, {31'd0, ~VECS[i].expWe});
    end

    // sweep every function code: R10 illegal decode, R8 flag pass-through
    for (int f = 0; f < 64; f++) begin
      logic expLegal;
      logic ccCode;
      expLegal = (f <= 8) || (f >= 16 && f <= 24) || (f >= 37 && f <= 39);
      ccCode   = (f >= 16 && f <= 24);
      apply(6'(f), 1'b0, 32'h55, 32'h3, 32'd0, 4'b1010);
      check($sformatf("R10 code %0h illegal", f), {31'd0, illegalOp}, {31'd0, ~expLegal});
      if (!ccCode)
        check($sformatf("R8 code %0h flags", f), {28'd0, flagsOut}, 32'hA);
    end

    // R3: flag form gives the same result as its plain twin
    for (int f = 0; f <= 8; f++) begin
      logic [31:0] plainR;
      apply(6'(f), 1'b0, 32'h9ABC0123, 32'h00F0F00F, 32'd0, 4'b0001);
      plainR = result;
      apply(6'(f + 16), 1'b0, 32'h9ABC0123, 32'h00F0F00F, 32'd0, 4'b0001);
      check($sformatf("R3 twin %0h result", f), result, plainR);
    end

    // R2: register form ignores immExt
    apply(6'h02, 1'b0, 32'h0, 32'h00000011, 32'hFFFF0000, 4'b0000);
    check("R2 reg form ignores immExt", result, 32'h00000011);

    finish();
  end

endmodule